// File: doc/BRIEF.md
# Redundant-Execution Commit Checker

This block is the commit end of an out-of-order core, built as a circular reorder buffer that will not retire any instruction until it has been executed twice. Dispatch allocates an entry for each instruction in program order. The first execution result is written back into that entry. When the entry reaches the head of the buffer and its first result is present, the buffer sends the instruction to an execution unit a second time.

That second send uses only issue slots that the normal issue path has left free in that cycle, and only after a programmable stagger delay. The delay keeps a single transient upset from corrupting both executions. For memory operations, only the address computation is repeated; the memory access itself happens once, at retire.

When the second result returns, it is compared with the stored first result. Equal results retire the entry. Unequal results raise an error, squash every entry from the faulty one onward, and give the fetch unit the faulty instruction's address to restart from. Errors are taken as transient, so one retry after the flush is enough. The comparator is taken to be fault-free.

Top module: `rdc_commit_rob`

## Requirements
- R1: After reset the buffer is empty. `alloc_ready` is 1, `alloc_tag` is 0, and `rissue_valid`, `retire_valid`, `flush` and `err_detect` are 0.
- R2: An allocation is taken when `alloc_valid` and `alloc_ready` are both 1. Tags are handed out in ascending order modulo DEPTH, starting from the current tail. `alloc_ready` is 0 while DEPTH entries are held.
- R3: A first-result writeback stores `wb1_data` in the entry named by `wb1_tag`. An entry never retires before its second result has returned.
- R4: Only the head entry is re-sent. The earliest cycle it can be re-sent is `w + 1 + MIN_GAP`, where `w` is the cycle of its first writeback. In any cycle that meets this and the slot condition of R5, `rissue_valid` is 1 and carries the head's tag, pc and class.
- R5: `rissue_valid` is 1 only in a cycle where `slot_free[cls]` is 1 for the head's class `cls`. While that bit is 0 the request waits.
- R6: At most one redundant send per entry is outstanding. `rissue_valid` is 0 in the cycle after a send and stays 0 until that entry has left the buffer.
- R7: `rissue_addr_only` is 1 exactly when the re-sent entry was allocated with `alloc_mem` = 1.
- R8: If the second result equals the first, `retire_valid` is 1 in the cycle after the `wb2_valid` cycle, with `retire_tag`, `retire_pc` and `retire_data` (the first result) of that entry. Entries retire in allocation order.
- R9: If the second result differs, then in the cycle after `wb2_valid`, `err_detect` and `flush` are 1, `retire_valid` is 0, and `restart_pc` equals the faulty entry's pc.
- R10: A flush drops every entry. `alloc_ready` is 0 during the flush cycle. In the following cycle `alloc_ready` is 1, `alloc_tag` equals the faulty entry's tag, and no squashed entry is ever re-sent or retired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Dispatch offers an instruction |
| alloc_pc | input | PC_W | Instruction address |
| alloc_cls | input | CLS_W | Execution unit class needed |
| alloc_mem | input | 1 | Instruction is a memory access |
| alloc_ready | output | 1 | Buffer can take an instruction |
| alloc_tag | output | IDX_W | Tag given to the offered instruction |
| wb1_valid | input | 1 | First result valid |
| wb1_tag | input | IDX_W | Entry of the first result |
| wb1_data | input | DATA_W | First result value |
| slot_free | input | NUM_CLS | Per class: slot left idle by normal issue this cycle |
| rissue_valid | output | 1 | Redundant send of the head entry |
| rissue_tag | output | IDX_W | Tag of the re-sent entry |
| rissue_pc | output | PC_W | Address of the re-sent instruction |
| rissue_cls | output | CLS_W | Class of the re-sent instruction |
| rissue_addr_only | output | 1 | Repeat address computation only |
| wb2_valid | input | 1 | Second result valid |
| wb2_tag | input | IDX_W | Entry of the second result |
| wb2_data | input | DATA_W | Second result value |
| retire_valid | output | 1 | Head entry retires |
| retire_tag | output | IDX_W | Tag of the retiring entry |
| retire_pc | output | PC_W | Address of the retiring instruction |
| retire_data | output | DATA_W | Checked result |
| err_detect | output | 1 | Result mismatch detected |
| flush | output | 1 | Squash all entries |
| restart_pc | output | PC_W | Fetch restart address |

## Verification
The assertions take some things for granted about the environment:
- A first result arrives exactly once, for an allocated entry.
- A second result arrives only for the head entry after its redundant send.
- Every class value is below NUM_CLS.
- Dispatch does not count an offer made while `alloc_ready` is low as taken.

The stimulus keeps within these assumptions by working in rounds. Each round allocates a random number of entries and then writes back their first results in shuffled order, with every `slot_free` bit held low. It then drains the entries one head at a time under random `slot_free` patterns. The second result for each entry is sent only after the bench has seen its send, and it is corrupted by a single bit flip on chosen entries.

// File: rtl/rdc_pkg.sv
`timescale 1ns/1ps
package rdc_pkg;

   // Life cycle of one buffer entry while its valid bit is set
   typedef enum logic [1:0] {
      ST_ALLOC = 2'd0,   // waiting for first result
      ST_DONE1 = 2'd1,   // first result stored
      ST_REDO  = 2'd2,   // redundant copy sent
      ST_DONE2 = 2'd3    // second result compared, verdict held
   } ent_state_e;

   function automatic int unsigned clog2_min1(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/rdc_ring_ctrl.sv
`timescale 1ns/1ps
module rdc_ring_ctrl
   import rdc_pkg::*;
#(
   parameter  int unsigned DEPTH = 8,
   localparam int unsigned IDX_W = clog2_min1(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic             flush,
   output logic [IDX_W-1:0] head,
   output logic [IDX_W-1:0] tail,
   output logic             full,
   output logic             empty
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

   logic [IDX_W-1:0] head_q, tail_q;
   logic [CNT_W-1:0] cnt_q;

   initial begin
      assert (DEPTH >= 2) else $error("rdc_ring_ctrl: DEPTH must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
      end else if (flush) begin
         tail_q <= head_q;
         cnt_q  <= '0;
      end else begin
         if (push) tail_q <= (tail_q == LAST_IDX) ? '0 : tail_q + 1'b1;
         if (pop)  head_q <= (head_q == LAST_IDX) ? '0 : head_q + 1'b1;
         cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
      end
   end

   assign head  = head_q;
   assign tail  = tail_q;
   assign full  = (cnt_q == CNT_W'(DEPTH));
   assign empty = (cnt_q == '0);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !push);  // R2
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);  // R10
   AST_HEAD_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !flush) |=> (head != $past(head)));  // R8

endmodule

// File: rtl/rdc_entry_array.sv
`timescale 1ns/1ps
module rdc_entry_array
   import rdc_pkg::*;
#(
   parameter  int unsigned DEPTH   = 8,
   parameter  int unsigned PC_W    = 32,
   parameter  int unsigned DATA_W  = 32,
   parameter  int unsigned CLS_W   = 1,
   parameter  int unsigned MIN_GAP = 2,
   localparam int unsigned IDX_W   = clog2_min1(DEPTH),
   localparam int unsigned GAP_W   = clog2_min1(MIN_GAP + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [IDX_W-1:0]  tail,
   input  logic [PC_W-1:0]   in_pc,
   input  logic [CLS_W-1:0]  in_cls,
   input  logic              in_mem,
   input  logic              wb1_valid,
   input  logic [IDX_W-1:0]  wb1_tag,
   input  logic [DATA_W-1:0] wb1_data,
   input  logic [IDX_W-1:0]  head,
   input  logic              set_redo,
   input  logic              set_done2,
   input  logic              pop,
   output logic              head_valid,
   output ent_state_e        head_state,
   output logic              head_gap_ok,
   output logic [PC_W-1:0]   head_pc,
   output logic [CLS_W-1:0]  head_cls,
   output logic              head_mem,
   output logic [DATA_W-1:0] head_res
);

   logic [DEPTH-1:0]  vld_q;
   ent_state_e        st_q  [DEPTH];
   logic [PC_W-1:0]   pc_q  [DEPTH];
   logic [CLS_W-1:0]  cls_q [DEPTH];
   logic [DEPTH-1:0]  mem_q;
   logic [DATA_W-1:0] res_q [DEPTH];
   logic [DEPTH-1:0]  wb1_hit;
   logic [DEPTH-1:0]  gap_ok;

   initial begin
      assert (PC_W >= 1 && DATA_W >= 1) else $error("rdc_entry_array: widths must be positive");
   end

   // First result accepted only by a live entry still waiting for it
   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         wb1_hit[i] = wb1_valid && (wb1_tag == IDX_W'(i)) && vld_q[i] && (st_q[i] == ST_ALLOC);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         for (int i = 0; i < DEPTH; i++) st_q[i] <= ST_ALLOC;
      end else if (flush) begin
         vld_q <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (push && (tail == IDX_W'(i))) begin
               vld_q[i] <= 1'b1;
               st_q[i]  <= ST_ALLOC;
            end else begin
               if (pop && (head == IDX_W'(i)))       vld_q[i] <= 1'b0;
               if (wb1_hit[i])                       st_q[i]  <= ST_DONE1;
               if (set_redo && (head == IDX_W'(i)))  st_q[i]  <= ST_REDO;
               if (set_done2 && (head == IDX_W'(i))) st_q[i]  <= ST_DONE2;
            end
         end
      end
   end

   // Payload storage carries no reset: it is read only under a valid bit
   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (push && (tail == IDX_W'(i))) begin
            pc_q[i]  <= in_pc;
            cls_q[i] <= in_cls;
            mem_q[i] <= in_mem;
         end
         if (wb1_hit[i]) res_q[i] <= wb1_data;
      end
   end

   // Stagger between first completion and redundant send
   generate
      if (MIN_GAP == 0) begin : g_no_gap
         assign gap_ok = '1;
      end else begin : g_gap
         logic [GAP_W-1:0] gap_q [DEPTH];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) gap_q[i] <= '0;
            end else begin
               for (int i = 0; i < DEPTH; i++) begin
                  if (wb1_hit[i])
                     gap_q[i] <= '0;
                  else if ((st_q[i] == ST_DONE1) && (gap_q[i] != GAP_W'(MIN_GAP)))
                     gap_q[i] <= gap_q[i] + 1'b1;
               end
            end
         end
         always_comb begin
            for (int i = 0; i < DEPTH; i++) gap_ok[i] = (gap_q[i] == GAP_W'(MIN_GAP));
         end
      end
   endgenerate

   assign head_valid  = vld_q[head];
   assign head_state  = st_q[head];
   assign head_gap_ok = gap_ok[head];
   assign head_pc     = pc_q[head];
   assign head_cls    = cls_q[head];
   assign head_mem    = mem_q[head];
   assign head_res    = res_q[head];

   AST_REDO_STAGGER: assert property (@(posedge clk) disable iff (!rst_n)
      set_redo |-> !$past(wb1_valid && (wb1_tag == head)));  // R4

endmodule

// File: rtl/rdc_redo_unit.sv
`timescale 1ns/1ps
module rdc_redo_unit
   import rdc_pkg::*;
#(
   parameter  int unsigned NUM_CLS = 2,
   parameter  int unsigned CLS_W   = 1,
   parameter  int unsigned DATA_W  = 32,
   parameter  int unsigned IDX_W   = 3,
   localparam int unsigned PAD_N   = 1 << CLS_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [IDX_W-1:0]   head,
   input  logic               head_valid,
   input  ent_state_e         head_state,
   input  logic               head_gap_ok,
   input  logic [CLS_W-1:0]   head_cls,
   input  logic [DATA_W-1:0]  head_res,
   input  logic [NUM_CLS-1:0] slot_free,
   input  logic               wb2_valid,
   input  logic [IDX_W-1:0]   wb2_tag,
   input  logic [DATA_W-1:0]  wb2_data,
   output logic               redo_fire,
   output logic               done2_set,
   output logic               retire_go,
   output logic               error_go
);

   logic [PAD_N-1:0] slot_pad;
   logic             match_q;

   initial begin
      assert (NUM_CLS >= 1 && NUM_CLS <= PAD_N) else $error("rdc_redo_unit: class width too small");
   end

   // Classes beyond NUM_CLS never see a free slot
   generate
      if (PAD_N == NUM_CLS) begin : g_exact
         assign slot_pad = slot_free;
      end else begin : g_pad
         assign slot_pad = {{(PAD_N - NUM_CLS){1'b0}}, slot_free};
      end
   endgenerate

   assign redo_fire = head_valid && (head_state == ST_DONE1) && head_gap_ok && slot_pad[head_cls];
   assign done2_set = wb2_valid && head_valid && (head_state == ST_REDO) && (wb2_tag == head);

   always_ff @(posedge clk) begin
      if (!rst_n)         match_q <= 1'b0;
      else if (done2_set) match_q <= (wb2_data == head_res);
   end

   assign retire_go = head_valid && (head_state == ST_DONE2) && match_q;
   assign error_go  = head_valid && (head_state == ST_DONE2) && !match_q;

   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      redo_fire |=> !redo_fire);  // R6
   AST_VERDICT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      done2_set |=> (retire_go || error_go));  // R8

endmodule

// File: rtl/rdc_commit_rob.sv
`timescale 1ns/1ps
module rdc_commit_rob
   import rdc_pkg::*;
#(
   parameter  int unsigned DEPTH   = 8,
   parameter  int unsigned PC_W    = 32,
   parameter  int unsigned DATA_W  = 32,
   parameter  int unsigned NUM_CLS = 2,
   parameter  int unsigned MIN_GAP = 2,
   localparam int unsigned IDX_W   = clog2_min1(DEPTH),
   localparam int unsigned CLS_W   = clog2_min1(NUM_CLS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               alloc_valid,
   input  logic [PC_W-1:0]    alloc_pc,
   input  logic [CLS_W-1:0]   alloc_cls,
   input  logic               alloc_mem,
   output logic               alloc_ready,
   output logic [IDX_W-1:0]   alloc_tag,
   input  logic               wb1_valid,
   input  logic [IDX_W-1:0]   wb1_tag,
   input  logic [DATA_W-1:0]  wb1_data,
   input  logic [NUM_CLS-1:0] slot_free,
   output logic               rissue_valid,
   output logic [IDX_W-1:0]   rissue_tag,
   output logic [PC_W-1:0]    rissue_pc,
   output logic [CLS_W-1:0]   rissue_cls,
   output logic               rissue_addr_only,
   input  logic               wb2_valid,
   input  logic [IDX_W-1:0]   wb2_tag,
   input  logic [DATA_W-1:0]  wb2_data,
   output logic               retire_valid,
   output logic [IDX_W-1:0]   retire_tag,
   output logic [PC_W-1:0]    retire_pc,
   output logic [DATA_W-1:0]  retire_data,
   output logic               err_detect,
   output logic               flush,
   output logic [PC_W-1:0]    restart_pc
);

   logic [IDX_W-1:0]  head, tail;
   logic              full, empty;
   logic              push, pop;
   logic              head_valid, head_gap_ok, head_mem;
   ent_state_e        head_state;
   logic [PC_W-1:0]   head_pc;
   logic [CLS_W-1:0]  head_cls;
   logic [DATA_W-1:0] head_res;
   logic              redo_fire, done2_set, retire_go, error_go;

   assign alloc_ready = !full && !error_go;
   assign push        = alloc_valid && alloc_ready;
   assign pop         = retire_go;

   rdc_ring_ctrl #(.DEPTH(DEPTH)) u_ring (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .pop   (pop),
      .flush (error_go),
      .head  (head),
      .tail  (tail),
      .full  (full),
      .empty (empty)
   );

   rdc_entry_array #(
      .DEPTH   (DEPTH),
      .PC_W    (PC_W),
      .DATA_W  (DATA_W),
      .CLS_W   (CLS_W),
      .MIN_GAP (MIN_GAP)
   ) u_entries (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush       (error_go),
      .push        (push),
      .tail        (tail),
      .in_pc       (alloc_pc),
      .in_cls      (alloc_cls),
      .in_mem      (alloc_mem),
      .wb1_valid   (wb1_valid),
      .wb1_tag     (wb1_tag),
      .wb1_data    (wb1_data),
      .head        (head),
      .set_redo    (redo_fire),
      .set_done2   (done2_set),
      .pop         (pop),
      .head_valid  (head_valid),
      .head_state  (head_state),
      .head_gap_ok (head_gap_ok),
      .head_pc     (head_pc),
      .head_cls    (head_cls),
      .head_mem    (head_mem),
      .head_res    (head_res)
   );

   rdc_redo_unit #(
      .NUM_CLS (NUM_CLS),
      .CLS_W   (CLS_W),
      .DATA_W  (DATA_W),
      .IDX_W   (IDX_W)
   ) u_redo (
      .clk         (clk),
      .rst_n       (rst_n),
      .head        (head),
      .head_valid  (head_valid),
      .head_state  (head_state),
      .head_gap_ok (head_gap_ok),
      .head_cls    (head_cls),
      .head_res    (head_res),
      .slot_free   (slot_free),
      .wb2_valid   (wb2_valid),
      .wb2_tag     (wb2_tag),
      .wb2_data    (wb2_data),
      .redo_fire   (redo_fire),
      .done2_set   (done2_set),
      .retire_go   (retire_go),
      .error_go    (error_go)
   );

   assign alloc_tag        = tail;
   assign rissue_valid     = redo_fire;
   assign rissue_tag       = head;
   assign rissue_pc        = head_pc;
   assign rissue_cls       = head_cls;
   assign rissue_addr_only = head_mem;
   assign retire_valid     = retire_go;
   assign retire_tag       = head;
   assign retire_pc        = head_pc;
   assign retire_data      = head_res;
   assign err_detect       = error_go;
   assign flush            = error_go;
   assign restart_pc       = head_pc;

   AST_SLOT_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
      rissue_valid |-> ((32'(rissue_cls) < NUM_CLS) && slot_free[rissue_cls]));  // R5
   AST_NO_RETIRE_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !retire_valid);  // R9
   AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !(rissue_valid || retire_valid || flush));  // R10

endmodule

// File: tb/test_rdc_commit_rob.sv
`timescale 1ns/1ps
module test_rdc_commit_rob;

   localparam int DEPTH   = 8;
   localparam int PC_W    = 32;
   localparam int DATA_W  = 32;
   localparam int NUM_CLS = 2;
   localparam int MIN_GAP = 2;
   localparam int IDX_W   = 3;
   localparam int CLS_W   = 1;

   logic               clk = 1'b0;
   logic               rst_n;
   logic               alloc_valid;
   logic [PC_W-1:0]    alloc_pc;
   logic [CLS_W-1:0]   alloc_cls;
   logic               alloc_mem;
   logic               alloc_ready;
   logic [IDX_W-1:0]   alloc_tag;
   logic               wb1_valid;
   logic [IDX_W-1:0]   wb1_tag;
   logic [DATA_W-1:0]  wb1_data;
   logic [NUM_CLS-1:0] slot_free;
   logic               rissue_valid;
   logic [IDX_W-1:0]   rissue_tag;
   logic [PC_W-1:0]    rissue_pc;
   logic [CLS_W-1:0]   rissue_cls;
   logic               rissue_addr_only;
   logic               wb2_valid;
   logic [IDX_W-1:0]   wb2_tag;
   logic [DATA_W-1:0]  wb2_data;
   logic               retire_valid;
   logic [IDX_W-1:0]   retire_tag;
   logic [PC_W-1:0]    retire_pc;
   logic [DATA_W-1:0]  retire_data;
   logic               err_detect;
   logic               flush;
   logic [PC_W-1:0]    restart_pc;

   rdc_commit_rob #(
      .DEPTH(DEPTH), .PC_W(PC_W), .DATA_W(DATA_W), .NUM_CLS(NUM_CLS), .MIN_GAP(MIN_GAP)
   ) i_rdc_commit_rob (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_pc(alloc_pc), .alloc_cls(alloc_cls), .alloc_mem(alloc_mem),
      .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
      .wb1_valid(wb1_valid), .wb1_tag(wb1_tag), .wb1_data(wb1_data),
      .slot_free(slot_free),
      .rissue_valid(rissue_valid), .rissue_tag(rissue_tag), .rissue_pc(rissue_pc),
      .rissue_cls(rissue_cls), .rissue_addr_only(rissue_addr_only),
      .wb2_valid(wb2_valid), .wb2_tag(wb2_tag), .wb2_data(wb2_data),
      .retire_valid(retire_valid), .retire_tag(retire_tag), .retire_pc(retire_pc),
      .retire_data(retire_data), .err_detect(err_detect), .flush(flush), .restart_pc(restart_pc)
   );

   always #2.5 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 1'b0;
   int m_tail = 0;
   int m_head = 0;

   logic [PC_W-1:0]   e_pc  [DEPTH];
   logic [CLS_W-1:0]  e_cls [DEPTH];
   logic              e_mem [DEPTH];
   logic [DATA_W-1:0] e_res [DEPTH];
   int                e_tag [DEPTH];
   int                e_w1  [DEPTH];

   function automatic int tag_inc(input int t);
      return (t == DEPTH - 1) ? 0 : t + 1;
   endfunction

   function automatic bit redo_expected(input int now, input int w1, input bit free);
      return (now >= w1 + 1 + MIN_GAP) && free;
   endfunction

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic next_cycle();
      @(negedge clk);
      cyc++;
   endtask

   task automatic clear_inputs();
      alloc_valid = 1'b0; alloc_pc = '0; alloc_cls = '0; alloc_mem = 1'b0;
      wb1_valid = 1'b0; wb1_tag = '0; wb1_data = '0;
      wb2_valid = 1'b0; wb2_tag = '0; wb2_data = '0;
   endtask

   task automatic run_round(input int k, input int bad_pos, input int hold);
      int ord [DEPTH];
      bit hit_bad = 1'b0;
      // allocation phase, no slot offered so nothing is re-sent
      for (int i = 0; i < k; i++) begin
         next_cycle();
         clear_inputs();
         slot_free = '0;
         e_pc[i]  = $urandom;
         e_cls[i] = CLS_W'($urandom % NUM_CLS);
         e_mem[i] = 1'($urandom % 2);
         e_res[i] = $urandom;
         alloc_valid = 1'b1; alloc_pc = e_pc[i]; alloc_cls = e_cls[i]; alloc_mem = e_mem[i];
         #1;
         chk("R2", "alloc_ready", 64'(alloc_ready), 64'd1);
         chk("R2", "alloc_tag", 64'(alloc_tag), 64'(m_tail));
         chk("R5", "rissue_valid no slot", 64'(rissue_valid), 64'd0);
         e_tag[i] = m_tail;
         m_tail = tag_inc(m_tail);
      end
      if (k == DEPTH) begin
         next_cycle();
         clear_inputs();
         alloc_valid = 1'b1; alloc_pc = $urandom;
         #1;
         chk("R2", "alloc_ready when full", 64'(alloc_ready), 64'd0);
      end
      // first results in shuffled order
      for (int i = 0; i < k; i++) ord[i] = i;
      for (int i = k - 1; i > 0; i--) begin
         int j = int'($urandom % (i + 1));
         int t = ord[i];
         ord[i] = ord[j];
         ord[j] = t;
      end
      for (int i = 0; i < k; i++) begin
         next_cycle();
         clear_inputs();
         slot_free = '0;
         wb1_valid = 1'b1; wb1_tag = IDX_W'(e_tag[ord[i]]); wb1_data = e_res[ord[i]];
         e_w1[ord[i]] = cyc;
         #1;
         chk("R5", "rissue_valid no slot", 64'(rissue_valid), 64'd0);
         chk("R3", "retire_valid before check", 64'(retire_valid), 64'd0);
      end
      // drain in order
      for (int p = 0; p < k && !hit_bad; p++) begin
         bit fired = 1'b0;
         int it = 0;
         while (!fired) begin
            bit exp;
            next_cycle();
            clear_inputs();
            if (it < hold)    slot_free = '0;
            else if (it > 12) slot_free = '1;
            else              slot_free = NUM_CLS'($urandom);
            #1;
            exp = redo_expected(cyc, e_w1[p], slot_free[e_cls[p]]);
            chk("R4", "rissue_valid timing/slot (R5)", 64'(rissue_valid), 64'(exp));
            chk("R3", "retire_valid before second result", 64'(retire_valid), 64'd0);
            if (exp) begin
               chk("R4", "rissue_tag", 64'(rissue_tag), 64'(e_tag[p]));
               chk("R4", "rissue_pc", 64'(rissue_pc), 64'(e_pc[p]));
               chk("R4", "rissue_cls", 64'(rissue_cls), 64'(e_cls[p]));
               chk("R7", "rissue_addr_only", 64'(rissue_addr_only), 64'(e_mem[p]));
               fired = 1'b1;
            end
            it++;
            if (it > 40) fired = 1'b1;
         end
         next_cycle();
         clear_inputs();
         slot_free = '1;
         wb2_valid = 1'b1; wb2_tag = IDX_W'(e_tag[p]);
         wb2_data  = (p == bad_pos) ? (e_res[p] ^ (32'd1 << ($urandom % 32))) : e_res[p];
         #1;
         chk("R6", "rissue_valid while outstanding", 64'(rissue_valid), 64'd0);
         chk("R3", "retire_valid on wb2 cycle", 64'(retire_valid), 64'd0);
         next_cycle();
         clear_inputs();
         slot_free = NUM_CLS'($urandom);
         #1;
         chk("R6", "rissue_valid during verdict", 64'(rissue_valid), 64'd0);
         if (p == bad_pos) begin
            chk("R9", "err_detect", 64'(err_detect), 64'd1);
            chk("R9", "flush", 64'(flush), 64'd1);
            chk("R9", "retire_valid on mismatch", 64'(retire_valid), 64'd0);
            chk("R9", "restart_pc", 64'(restart_pc), 64'(e_pc[p]));
            chk("R10", "alloc_ready during flush", 64'(alloc_ready), 64'd0);
            m_head = e_tag[p];
            m_tail = e_tag[p];
            hit_bad = 1'b1;
         end else begin
            chk("R8", "retire_valid", 64'(retire_valid), 64'd1);
            chk("R8", "retire_tag", 64'(retire_tag), 64'(e_tag[p]));
            chk("R8", "retire_pc", 64'(retire_pc), 64'(e_pc[p]));
            chk("R8", "retire_data", 64'(retire_data), 64'(e_res[p]));
            chk("R9", "flush on match", 64'(flush), 64'd0);
            m_head = tag_inc(m_head);
         end
      end
      next_cycle();
      clear_inputs();
      slot_free = '1;
      #1;
      chk("R10", "alloc_ready after round", 64'(alloc_ready), 64'd1);
      chk("R10", "alloc_tag after round", 64'(alloc_tag), 64'(m_tail));
      chk("R10", "retire_valid when empty", 64'(retire_valid), 64'd0);
      if (hit_bad) begin
         for (int c = 0; c < 3; c++) begin
            next_cycle();
            #1;
            chk("R10", "no squashed entry re-sent", 64'(rissue_valid), 64'd0);
            chk("R10", "no squashed entry retired", 64'(retire_valid), 64'd0);
         end
      end
   endtask

   task automatic finish_up();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog R8: actual hung expected finished");
         finish_up();
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0;
      clear_inputs();
      slot_free = '0;
      repeat (4) next_cycle();
      rst_n = 1'b1;
      next_cycle();
      #1;
      chk("R1", "alloc_ready", 64'(alloc_ready), 64'd1);
      chk("R1", "alloc_tag", 64'(alloc_tag), 64'd0);
      chk("R1", "rissue_valid", 64'(rissue_valid), 64'd0);
      chk("R1", "retire_valid", 64'(retire_valid), 64'd0);
      chk("R1", "flush", 64'(flush), 64'd0);
      chk("R1", "err_detect", 64'(err_detect), 64'd0);

      run_round(1, -1, 0);          // single entry, clean pass
      run_round(1, -1, 6);          // slot held busy before send (R5)
      run_round(3, 1, 0);           // mismatch on a middle entry
      run_round(DEPTH, -1, 0);      // fill completely (R2), wrap tags
      run_round(4, 0, 2);           // mismatch on the head itself
      run_round(DEPTH, DEPTH - 1, 1);
      for (int r = 0; r < 60; r++) begin
         int k = 1 + int'($urandom % DEPTH);
         int bad = ($urandom % 4 == 0) ? int'($urandom % k) : -1;
         run_round(k, bad, int'($urandom % 3));
      end
      finish_up();
   end

endmodule